// File: doc/BRIEF.md
# Five-Function Integer ALU

A combinational arithmetic logic unit for a datapath of configurable width (32 bits by default). Two two's complement operands and a 3-bit function code go in. Out come a result word, a carry flag, a signed overflow flag and a zero flag. The unit performs bitwise AND and OR, addition, subtraction and a signed set-on-less-than.

A single adder serves addition, subtraction and the comparison. Bit 2 of the function code inverts the second operand and forces the adder carry-in to one, so the adder computes A + ~B + 1. Overflow comes from comparing the carry that enters the top bit with the carry that leaves it. The comparison puts the sign of the raw difference in bit 0.

Two adder structures can be picked by parameter. One is an explicit bit-cell ripple chain. The other is a behavioural sum split at the top bit. Both give the same port behaviour.

Top module: `int_alu5`

## Requirements
- R1: Function code 000 gives the bitwise AND of the operands; carry and overflow are 0.
- R2: Function code 001 gives the bitwise OR of the operands; carry and overflow are 0.
- R3: Function code 010 gives (A + B) modulo 2^WIDTH, and carry is the adder's carry out of the most significant bit.
- R4: Function code 110 gives (A + ~B + 1) modulo 2^WIDTH, which is A - B. Carry is the adder's final carry, so it is 1 exactly when A >= B as unsigned numbers.
- R5: The overflow flag is 1 only under code 010 or 110, and only when the two's complement sum or difference lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1]. This is the carry into the top bit XOR the carry out of it.
- R6: Function code 111 puts bit WIDTH-1 of A + ~B + 1 (the raw sign, with no overflow correction) in result bit 0 and 0 in every other result bit; carry and overflow are 0.
- R7: The zero flag is 1 exactly when every result bit is 0, under every function code.
- R8: Function codes 011, 100 and 101 give a result of all zeros with carry and overflow cleared (and so, by R7, zero set).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand, two's complement |
| b_i | input | WIDTH | Second operand, two's complement |
| op_i | input | 3 | Function code; bit 2 selects inverted B with carry-in 1 |
| result_o | output | WIDTH | Result word |
| carry_o | output | 1 | Adder carry out for add and subtract, else 0 |
| overflow_o | output | 1 | Signed overflow for add and subtract, else 0 |
| zero_o | output | 1 | 1 when the result is all zeros |

## Verification
The bench sweeps every operand pair and every function code on a 4-bit build of both adder variants. It computes each output arithmetically.

This sweep covers the overflow edges: -8 - 1, 7 + 1 and -8 + -8. A design that took overflow from the carry out alone would flag unsigned wrap instead. A subtract that left carry-in at 0 would be off by one everywhere.

Set-on-less-than is checked against the raw difference sign, so a version that corrected for overflow would be caught at 7 versus -1. The sweep also hits the unused codes and the carry masking under logic operations, where a leaked adder carry or a stale result would show.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [2:0] {
      OP_AND = 3'b000,
      OP_OR  = 3'b001,
      OP_ADD = 3'b010,
      OP_SUB = 3'b110,
      OP_SLT = 3'b111
   } alu_op_e;

   typedef enum logic [2:0] {
      SEL_AND,
      SEL_OR,
      SEL_SUM,
      SEL_SLT,
      SEL_NONE
   } res_sel_e;

   typedef struct packed {
      logic     invert_b;
      logic     arith_flags;
      res_sel_e sel;
   } alu_ctrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
   import alu_pkg::*;
(
   input  logic [2:0] op_i,
   output alu_ctrl_t  ctrl_o
);

   always_comb begin
      ctrl_o = '{invert_b: 1'b0, arith_flags: 1'b0, sel: SEL_NONE};
      case (op_i)
         OP_AND: ctrl_o.sel = SEL_AND;
         OP_OR:  ctrl_o.sel = SEL_OR;
         OP_ADD: begin
            ctrl_o.sel         = SEL_SUM;
            ctrl_o.arith_flags = 1'b1;
         end
         OP_SUB: begin
            ctrl_o.sel         = SEL_SUM;
            ctrl_o.arith_flags = 1'b1;
            ctrl_o.invert_b    = 1'b1;
         end
         OP_SLT: begin
            ctrl_o.sel      = SEL_SLT;
            ctrl_o.invert_b = 1'b1;
         end
         default: ctrl_o.sel = SEL_NONE;
      endcase
   end

   // an invert request only ever comes with a listed subtract-type code
   always_comb begin
      if (ctrl_o.invert_b)
         AST_INVERT_FROM_BIT2: assert (op_i[2] && op_i[1]); // R4
   end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int WIDTH  = 32,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             invert_b_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             carry_msb_in_o,
   output logic             carry_o
);

   localparam int LOW_W = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;

   assign b_eff = invert_b_i ? ~b_i : b_i;

   if (RIPPLE) begin : g_ripple
      logic [WIDTH:0] c;
      assign c[0] = invert_b_i;
      for (genvar i = 0; i < WIDTH; i++) begin : g_cell
         logic p;
         assign p        = a_i[i] ^ b_eff[i];
         assign sum_o[i] = p ^ c[i];
         assign c[i+1]   = (a_i[i] & b_eff[i]) | (c[i] & p);
      end
      assign carry_msb_in_o = c[WIDTH-1];
      assign carry_o        = c[WIDTH];
   end else begin : g_split
      logic [LOW_W:0] low;
      logic [1:0]     top;
      assign low = {1'b0, a_i[LOW_W-1:0]} + {1'b0, b_eff[LOW_W-1:0]}
                 + {{LOW_W{1'b0}}, invert_b_i};
      assign top = {1'b0, a_i[WIDTH-1]} + {1'b0, b_eff[WIDTH-1]} + {1'b0, low[LOW_W]};
      assign sum_o          = {top[0], low[LOW_W-1:0]};
      assign carry_msb_in_o = low[LOW_W];
      assign carry_o        = top[1];
   end

   // with carry-in forced high the final carry means "no borrow"
   always_comb begin
      if (invert_b_i)
         AST_SUB_CARRY_NO_BORROW: assert (carry_o == (a_i >= b_i)); // R4
   end

endmodule

// File: rtl/int_alu5.sv
module int_alu5
   import alu_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [2:0]       op_i,
   output logic [WIDTH-1:0] result_o,
   output logic             carry_o,
   output logic             overflow_o,
   output logic             zero_o
);

   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_width_check
      $error("int_alu5: WIDTH must be at least 2");
   end

   alu_ctrl_t        ctrl;
   logic [WIDTH-1:0] sum;
   logic             c_msb_in;
   logic             c_out;

   alu_decode i_decode (
      .op_i   (op_i),
      .ctrl_o (ctrl)
   );

   alu_adder #(
      .WIDTH  (WIDTH),
      .RIPPLE (RIPPLE)
   ) i_adder (
      .a_i            (a_i),
      .b_i            (b_i),
      .invert_b_i     (ctrl.invert_b),
      .sum_o          (sum),
      .carry_msb_in_o (c_msb_in),
      .carry_o        (c_out)
   );

   always_comb begin
      case (ctrl.sel)
         SEL_AND: result_o = a_i & b_i;
         SEL_OR:  result_o = a_i | b_i;
         SEL_SUM: result_o = sum;
         SEL_SLT: result_o = {{MSB{1'b0}}, sum[MSB]};
         default: result_o = '0;
      endcase
   end

   assign carry_o    = ctrl.arith_flags & c_out;
   assign overflow_o = ctrl.arith_flags & (c_msb_in ^ c_out);
   assign zero_o     = ~|result_o;

   logic arith_code;
   logic unused_code;
   assign arith_code  = (op_i == OP_ADD) || (op_i == OP_SUB);
   assign unused_code = (op_i == 3'b011) || (op_i == 3'b100) || (op_i == 3'b101);

   always_comb begin
      if (carry_o)
         AST_CARRY_ARITH_ONLY: assert (arith_code); // R3
      if (overflow_o)
         AST_NO_OVERFLOW_OUTSIDE_ARITH: assert (arith_code); // R5
      if (overflow_o)
         AST_OVERFLOW_SIGN_FLIP: assert (a_i[MSB] == (b_i[MSB] ^ op_i[2]) && result_o[MSB] != a_i[MSB]); // R5
      if (op_i == OP_SLT)
         AST_SLT_UPPER_CLEAR: assert (result_o[MSB:1] == '0); // R6
      if (unused_code)
         AST_UNUSED_QUIET: assert (result_o == '0 && !carry_o && !overflow_o); // R8
      if (unused_code)
         AST_UNUSED_ZERO_SET: assert (zero_o); // R7
   end

endmodule

// File: tb/test_int_alu5.sv
module test_int_alu5;

   localparam int W = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   logic [W-1:0] a, b;
   logic [2:0]   op;
   logic [W-1:0] r0, r1;
   logic         c0, c1, v0, v1, z0, z1;

   int errors = 0;
   int checks = 0;

   int_alu5 #(.WIDTH(W), .RIPPLE(1'b1)) i_int_alu5 (
      .a_i(a), .b_i(b), .op_i(op),
      .result_o(r0), .carry_o(c0), .overflow_o(v0), .zero_o(z0)
   );

   int_alu5 #(.WIDTH(W), .RIPPLE(1'b0)) i_int_alu5_split (
      .a_i(a), .b_i(b), .op_i(op),
      .result_o(r1), .carry_o(c1), .overflow_o(v1), .zero_o(z1)
   );

   task automatic check(input string req, input string what, input logic [W-1:0] act, input int exp);
      checks++;
      if (act !== W'(exp)) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d (a=%0d b=%0d op=%b)",
                  req, what, act, exp, a, b, op);
      end
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      a  = '0;
      b  = '0;
      op = 3'b000;
      @(negedge clk);
      #5;
      // reset state: AND of zeros gives zero word with zero flag set
      check("R1", "reset result", r0, 0);
      check("R7", "reset zero", W'(z0), 1);
      rst = 1'b0;

      for (int o = 0; o < 8; o++) begin
         for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
               int sa, sb, s, er, ec, ev, ez;
               string tr;
               @(negedge clk);
               a  = W'(x);
               b  = W'(y);
               op = 3'(o);
               sa = (x >= 8) ? x - 16 : x;
               sb = (y >= 8) ? y - 16 : y;
               ec = 0;
               ev = 0;
               case (o)
                  0: begin er = x & y; tr = "R1"; end
                  1: begin er = x | y; tr = "R2"; end
                  2: begin
                     s  = x + y;
                     er = s % 16;
                     ec = s / 16;
                     ev = ((sa + sb) > 7 || (sa + sb) < -8) ? 1 : 0;
                     tr = "R3";
                  end
                  6: begin
                     s  = x + (15 - y) + 1;
                     er = s % 16;
                     ec = s / 16;
                     ev = ((sa - sb) > 7 || (sa - sb) < -8) ? 1 : 0;
                     tr = "R4";
                  end
                  7: begin
                     s  = x + (15 - y) + 1;
                     er = (s % 16) / 8;
                     tr = "R6";
                  end
                  default: begin er = 0; tr = "R8"; end
               endcase
               ez = (er == 0) ? 1 : 0;
               #5;
               check(tr, "result ripple", r0, er);
               check(tr, "result split", r1, er);
               check(tr, "carry ripple", W'(c0), ec);
               check(tr, "carry split", W'(c1), ec);
               check("R5", "overflow ripple", W'(v0), ev);
               check("R5", "overflow split", W'(v1), ev);
               check("R7", "zero ripple", W'(z0), ez);
               check("R7", "zero split", W'(z1), ez);
            end
         end
      end

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule